// File: doc/BRIEF.md
# Shared-Bus Multicycle Processor Datapath

This block is the data half of a 32-bit multicycle processor. The program counter, two ALU operand latches, a memory address register, an instruction register, a one-bit zero flag and a 16-entry register file all exchange values over one internal bus. There is no point-to-point wiring between these elements. In each cycle an external sequencer picks which single source places a value on the bus. It also picks which storage elements capture that value at the next rising edge.

The sequencer steers the block with plain strobes: five source enables, six capture enables, a register-write strobe, a memory-write strobe, a two-bit ALU operation code and a two-bit register selector. It receives back the four-bit opcode of the current instruction and the zero flag. Main memory sits outside the block. Its address always comes from the memory address register, and its write data is the bus. A fetch, for example, takes three steps: PC to the MAR and latch A, then memory to the IR, then A+1 to the PC.

Top module: `sbus_datapath`

## Requirements
- R1: After reset (rst_n low, asynchronous) the PC, latch A, latch B, MAR, IR, zero flag and every register-file entry are 0.
- R2: The bus carries the value of the one enabled source: PC, ALU result, register-file read port, mem_rdata or the sign-extended offset. With no source enabled the bus is 0. At most one source enable may be high in any cycle. The bus is visible on mem_wdata.
- R3: PC, A, B, MAR and IR each take the bus value at the rising edge when their own capture enable is high. Otherwise they keep their value.
- R4: The ALU computes from latch A and latch B with alu_op 0 = A+B, 1 = NOT(A AND B), 2 = A−B and 3 = A+1, all modulo 2^32.
- R5: The register selector picks the register-file index from the IR: 0 = IR[27:24], 1 = IR[23:20], 2 = IR[3:0], and 3 behaves like 0.
- R6: With put_reg high, the selected register takes the bus value at the rising edge. Reads are combinational, and register 0 is writable like any other.
- R7: The offset source is IR[19:0] sign-extended to 32 bits, so bit 19 is copied into bits 31:20.
- R8: With cap_z high, the zero flag takes 1 if the ALU result is 0 and 0 otherwise, computed from the operands held before the edge. With cap_z low the flag holds.
- R9: mem_addr always equals the MAR, mem_we follows put_mem, and mem_wdata is the bus.
- R10: The opcode output is IR[31:28].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pc | input | 1 | PC drives the bus |
| src_alu | input | 1 | ALU result drives the bus |
| src_reg | input | 1 | Register-file read port drives the bus |
| src_mem | input | 1 | Memory read data drives the bus |
| src_off | input | 1 | Sign-extended offset drives the bus |
| cap_pc | input | 1 | PC captures the bus |
| cap_a | input | 1 | Latch A captures the bus |
| cap_b | input | 1 | Latch B captures the bus |
| cap_mar | input | 1 | MAR captures the bus |
| cap_ir | input | 1 | IR captures the bus |
| cap_z | input | 1 | Zero flag captures the ALU zero test |
| put_reg | input | 1 | Selected register captures the bus |
| put_mem | input | 1 | Memory write request |
| alu_op | input | 2 | ALU operation code |
| rsel | input | 2 | Register-field selector |
| opcode | output | 4 | Opcode field of the IR |
| zero | output | 1 | Zero flag |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (bus) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bus driver and the capture paths meet in one cycle when the ALU result is put on the bus and captured back into latch A, while the zero flag samples the same result. The bench provokes this with equal operands and subtraction. It then judges that the zero flag is set from the old operands, and that a following A+B on the bus shows latch A now holds 0. A second overlap arises in the increment step of a fetch: the ALU output that depends on latch A is written into the PC. The bench judges this by reading the PC back over the bus.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_NAND = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_INC  = 2'd3
  } alu_op_e;

  localparam int NSRC    = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_ALU = 1;
  localparam int SRC_REG = 2;
  localparam int SRC_MEM = 3;
  localparam int SRC_OFF = 4;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   op,
  output logic [W-1:0] y,
  output logic         is_zero
);
  always_comb begin
    unique case (alu_op_e'(op))
      ALU_ADD:  y = opa + opb;
      ALU_NAND: y = ~(opa & opb);
      ALU_SUB:  y = opa - opb;
      default:  y = opa + {{(W-1){1'b0}}, 1'b1};
    endcase
  end

  assign is_zero = (y == '0);
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W = 32,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = regs[idx];

  // R6: a write lands in the addressed entry
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(idx)] == $past(wdata));
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int W    = 32,
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0]        en,
  input  logic [NSRC-1:0][W-1:0] src,
  output logic [W-1:0]           bus
);
  logic [NSRC-1:0][W-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = src[g] & {W{en[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
  end

  // R2: single-driver rule on the shared bus
  p_one_driver_r2: assert final ($countones(en) <= 1);
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W     = 32,
  parameter int NREG  = 16,
  parameter int OFF_W = 20,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_pc,
  input  logic         src_alu,
  input  logic         src_reg,
  input  logic         src_mem,
  input  logic         src_off,
  input  logic         cap_pc,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         cap_mar,
  input  logic         cap_ir,
  input  logic         cap_z,
  input  logic         put_reg,
  input  logic         put_mem,
  input  logic [1:0]   alu_op,
  input  logic [1:0]   rsel,
  output logic [3:0]   opcode,
  output logic         zero,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata
);
  logic [W-1:0] pc_q, a_q, b_q, mar_q, ir_q;
  logic         z_q;
  logic [W-1:0] bus, alu_y, rf_rdata, off_ext;
  logic         alu_zero;
  logic [RA_W-1:0] rf_idx;
  logic [NSRC-1:0]        drv_en;
  logic [NSRC-1:0][W-1:0] drv_val;

  // register-field decode
  always_comb begin
    unique case (rsel)
      SEL_Y:   rf_idx = ir_q[20 +: RA_W];
      SEL_Z:   rf_idx = ir_q[0 +: RA_W];
      default: rf_idx = ir_q[24 +: RA_W];
    endcase
  end

  assign off_ext = {{(W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

  assign drv_en[SRC_PC]   = src_pc;
  assign drv_en[SRC_ALU]  = src_alu;
  assign drv_en[SRC_REG]  = src_reg;
  assign drv_en[SRC_MEM]  = src_mem;
  assign drv_en[SRC_OFF]  = src_off;
  assign drv_val[SRC_PC]  = pc_q;
  assign drv_val[SRC_ALU] = alu_y;
  assign drv_val[SRC_REG] = rf_rdata;
  assign drv_val[SRC_MEM] = mem_rdata;
  assign drv_val[SRC_OFF] = off_ext;

  sbus_bus_mux #(.W(W), .NSRC(NSRC)) u_mux (
    .en  (drv_en),
    .src (drv_val),
    .bus (bus)
  );

  sbus_alu #(.W(W)) u_alu (
    .opa     (a_q),
    .opb     (b_q),
    .op      (alu_op),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  sbus_regfile #(.W(W), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (rf_idx),
    .we    (put_reg),
    .wdata (bus),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      z_q   <= 1'b0;
    end else begin
      if (cap_pc)  pc_q  <= bus;
      if (cap_a)   a_q   <= bus;
      if (cap_b)   b_q   <= bus;
      if (cap_mar) mar_q <= bus;
      if (cap_ir)  ir_q  <= bus;
      if (cap_z)   z_q   <= alu_zero;
    end
  end

  assign opcode    = ir_q[W-1 -: 4];
  assign zero      = z_q;
  assign mem_addr  = mar_q;
  assign mem_wdata = bus;
  assign mem_we    = put_mem;

  // R3: PC holds without its capture enable
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pc |=> $stable(pc_q));
  // R3: IR takes the bus value
  p_ir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ir |=> ir_q == $past(bus));
  // R8: zero flag reflects the pre-edge ALU result
  p_zero_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_z |=> zero == ($past(alu_y) == '0));
  // R8: zero flag holds otherwise
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_z |=> $stable(zero));
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic src_pc, src_alu, src_reg, src_mem, src_off;
  logic cap_pc, cap_a, cap_b, cap_mar, cap_ir, cap_z, put_reg, put_mem;
  logic [1:0] alu_op, rsel;
  logic [3:0] opcode;
  logic zero, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [64];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  sbus_datapath u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_pc(src_pc), .src_alu(src_alu), .src_reg(src_reg),
    .src_mem(src_mem), .src_off(src_off),
    .cap_pc(cap_pc), .cap_a(cap_a), .cap_b(cap_b), .cap_mar(cap_mar),
    .cap_ir(cap_ir), .cap_z(cap_z), .put_reg(put_reg), .put_mem(put_mem),
    .alu_op(alu_op), .rsel(rsel), .opcode(opcode), .zero(zero),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {src_pc, src_alu, src_reg, src_mem, src_off} = '0;
    {cap_pc, cap_a, cap_b, cap_mar, cap_ir, cap_z, put_reg, put_mem} = '0;
    alu_op = 2'd0;
    rsel = 2'd0;
  endtask

  // memory model writes on the edge, then strobes drop 1 ns after it
  task automatic tick();
    if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic bus_is(input string tag, input logic [31:0] exp);
    #1 chk(tag, mem_wdata, exp);
  endtask

  task automatic mem_to(input logic [31:0] v, input string dst, input logic [1:0] s);
    mem[8] = v;
    src_mem = 1'b1;
    rsel = s;
    case (dst)
      "A": cap_a = 1'b1;
      "B": cap_b = 1'b1;
      "IR": cap_ir = 1'b1;
      default: put_reg = 1'b1;
    endcase
    tick();
  endtask

  task automatic t_reset();
    chk("R1 opcode", {28'd0, opcode}, 32'd0);
    chk("R1 zero", {31'd0, zero}, 32'd0);
    chk("R1 mar", mem_addr, 32'd0);
    bus_is("R2 idle bus", 32'd0);
    src_pc = 1'b1; bus_is("R1 pc", 32'd0); idle();
    src_alu = 1'b1; alu_op = 2'd0; bus_is("R1 A+B", 32'd0); idle();
    src_reg = 1'b1; bus_is("R1 regfile", 32'd0); idle();
  endtask

  task automatic t_fetch();
    src_pc = 1'b1; cap_mar = 1'b1; cap_a = 1'b1; tick();
    chk("R9 addr", mem_addr, 32'd0);
    src_mem = 1'b1; cap_ir = 1'b1; tick();
    chk("R10 opcode", {28'd0, opcode}, 32'd5);
    src_alu = 1'b1; alu_op = 2'd3; cap_pc = 1'b1; tick();
    src_pc = 1'b1; bus_is("R3 pc incr", 32'd1); idle();
    src_off = 1'b1; bus_is("R7 neg offset", 32'hFFFF_FF29); idle();
    // point MAR at the scratch word
    src_pc = 1'b1; cap_mar = 1'b1; tick();
    src_mem = 1'b1; cap_mar = 1'b1; tick();
    chk("R3 mar load", mem_addr, 32'd8);
    repeat (3) tick();
    src_pc = 1'b1; bus_is("R3 pc hold", 32'd1); idle();
    chk("R3 ir hold", {28'd0, opcode}, 32'd5);
  endtask

  task automatic t_regs();
    mem_to(32'd100, "R", 2'd0);
    mem_to(32'hFFFF_FFF0, "R", 2'd1);
    mem_to(32'd37, "R", 2'd2);
    src_reg = 1'b1; rsel = 2'd0; bus_is("R5 sel Rx", 32'd100); idle();
    src_reg = 1'b1; rsel = 2'd1; bus_is("R5 sel Ry", 32'hFFFF_FFF0); idle();
    src_reg = 1'b1; rsel = 2'd2; bus_is("R5 sel Rz", 32'd37); idle();
    src_reg = 1'b1; rsel = 2'd3; bus_is("R5 sel 3", 32'd100); idle();
  endtask

  task automatic t_alu();
    src_reg = 1'b1; rsel = 2'd1; cap_a = 1'b1; tick();
    src_reg = 1'b1; rsel = 2'd2; cap_b = 1'b1; tick();
    src_alu = 1'b1;
    alu_op = 2'd0; bus_is("R4 add", 32'h0000_0015);
    alu_op = 2'd1; bus_is("R4 nand", 32'hFFFF_FFDF);
    alu_op = 2'd2; bus_is("R4 sub", 32'hFFFF_FFCB);
    alu_op = 2'd3; bus_is("R4 inc", 32'hFFFF_FFF1);
    idle();
  endtask

  task automatic t_zero();
    mem_to(32'h1234, "A", 2'd0);
    mem_to(32'h1234, "B", 2'd0);
    alu_op = 2'd2; cap_z = 1'b1; tick();
    chk("R8 zero set", {31'd0, zero}, 32'd1);
    mem_to(32'h1, "B", 2'd0);
    chk("R8 zero hold", {31'd0, zero}, 32'd1);
    alu_op = 2'd0; cap_z = 1'b1; tick();
    chk("R8 zero clear", {31'd0, zero}, 32'd0);
    // ALU result into A while the flag samples the same result
    mem_to(32'd5, "A", 2'd0);
    mem_to(32'd5, "B", 2'd0);
    src_alu = 1'b1; alu_op = 2'd2; cap_a = 1'b1; cap_z = 1'b1; tick();
    chk("R8 same-cycle zero", {31'd0, zero}, 32'd1);
    src_alu = 1'b1; alu_op = 2'd0; bus_is("R3 A from ALU", 32'd5); idle();
  endtask

  task automatic t_mem_write();
    src_reg = 1'b1; rsel = 2'd0; put_mem = 1'b1;
    #1 chk("R9 we", {31'd0, mem_we}, 32'd1);
    chk("R9 wdata", mem_wdata, 32'd100);
    tick();
    chk("R9 stored", mem[8], 32'd100);
    chk("R9 we low", {31'd0, mem_we}, 32'd0);
  endtask

  task automatic t_reg0_and_top();
    // opcode 9, Rx=0, Ry=2, Rz=15, offset 0x7FFFF
    mem_to({4'h9, 4'h0, 4'h2, 20'h7FFFF}, "IR", 2'd0);
    chk("R10 opcode 2", {28'd0, opcode}, 32'd9);
    src_off = 1'b1; bus_is("R7 pos offset", 32'h0007_FFFF); idle();
    mem_to(32'hDEAD_BEEF, "R", 2'd0);
    mem_to(32'h0BAD_F00D, "R", 2'd2);
    src_reg = 1'b1; rsel = 2'd0; bus_is("R6 reg0 write", 32'hDEAD_BEEF); idle();
    src_reg = 1'b1; rsel = 2'd2; bus_is("R6 reg15 write", 32'h0BAD_F00D); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[0] = {4'h5, 4'h3, 4'h7, 20'hFFF29};
    mem[1] = 32'd8;
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fetch();
    t_regs();
    t_alu();
    t_zero();
    t_mem_write();
    t_reg0_and_top();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule